// File: doc/BRIEF.md
# Slave-Mode DMA Handshake Engine

This block moves a programmed number of bytes between an external DMA controller and a local byte buffer. The two sides use an active-low request/acknowledge handshake on the same 8-bit data bus that the processor uses. Software programs the engine through a two-step access: a pointer write (select line low), then a data read or write (select line high) at that pointer.

To start a transfer, software writes a start address, a byte count and then a control byte holding the direction and an enable bit. The engine holds its request low while bytes remain. Each acknowledged strobe moves one byte to or from the buffer. The address then steps up by one and the count steps down by one. When the count reaches zero, the request is released and a sticky done flag and a one-cycle done pulse are raised.

Transfers only run while the device is in slave mode. While a transfer is active, processor accesses to the buffer are refused, but the control and status registers stay reachable so that software can abort.

Top module: `dma_xfer_engine`

## Requirements
- R1: A processor write with `a0`=0 sets the access pointer. A processor access with `a0`=1 reaches the location at that pointer. Pointer 0 is control (bit0 enable, bit1 direction, 1 = buffer to bus). Pointer 1 writes the start address and reads back the current transfer address. Pointer 2 writes the byte count and reads back the remaining count. Pointer 3 reads status (bit0 done, bit1 busy). Pointers 4 and above reach the buffer.
- R2: While `slave_mode` is low, `dma_req_n` stays high and acknowledged strobes move no data and leave the count unchanged.
- R3: A control write with enable set and a nonzero programmed count in slave mode drives `dma_req_n` low after the clock edge that takes the write.
- R4: In the write direction (bit1 = 0), each clock with `dma_ack_n` and `wr_n` low stores `bus_din` at the current address. It then increments the address and decrements the count.
- R5: In the read direction, each clock with `dma_ack_n` and `rd_n` low drives the buffer byte at the current address onto `bus_dout` with `bus_oe` high. It then advances the address and count in the same way.
- R6: After the edge that takes the final byte, `dma_req_n` is high, `xfer_done` is high and `done_pulse` is high for exactly one cycle.
- R7: Enabling with a programmed count of zero never asserts the request. It raises `xfer_done` and `done_pulse` after the edge that takes the control write.
- R8: While a transfer is active, processor buffer writes have no effect and processor buffer reads leave `bus_oe` low. Register accesses still work.
- R9: A control write with enable cleared during a transfer releases `dma_req_n` after that edge. `xfer_done` stays low and the remaining count holds.
- R10: After reset, `dma_req_n` is high, `xfer_done`, `done_pulse` and `bus_oe` are low, and the address, count and status registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slave_mode | input | 1 | High when the device runs as a peripheral; gates all transfers |
| cs_n | input | 1 | Processor chip select, active low |
| rd_n | input | 1 | Read strobe, active low (processor or DMA) |
| wr_n | input | 1 | Write strobe, active low (processor or DMA) |
| a0 | input | 1 | Access select: 0 = pointer, 1 = data |
| bus_din | input | 8 | Data from the shared bus |
| bus_dout | output | 8 | Data onto the shared bus |
| bus_oe | output | 1 | High while `bus_dout` should drive the bus |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| dma_req_n | output | 1 | DMA request, active low |
| xfer_done | output | 1 | Sticky transfer-complete flag |
| done_pulse | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The properties assume that every strobe is synchronous to the clock and lasts one cycle per byte. They also assume that `cs_n` and `dma_ack_n` are never low together and that `rd_n` and `wr_n` are never low at once. The bench drives each access as a one-cycle low pulse launched on the falling edge, and keeps chip select high whenever acknowledge is low. Random start addresses and counts are drawn so that each transfer stays inside the buffer region above the registers and never touches the guard byte used for the blocked-write check.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;

  localparam int unsigned RIDX_CTRL  = 0;
  localparam int unsigned RIDX_START = 1;
  localparam int unsigned RIDX_COUNT = 2;
  localparam int unsigned RIDX_STAT  = 3;
  localparam int unsigned NUM_REGS   = 4;

  typedef struct packed {
    logic dir;   // 1: buffer -> bus, 0: bus -> buffer
    logic en;
  } ctrl_t;

endpackage

// File: rtl/dmaeng_buf.sv
module dmaeng_buf #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/dmaeng_hostif.sv
module dmaeng_hostif
  import dmaeng_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          a0,
  input  logic          dma_ack_n,
  input  logic [DW-1:0] din,
  input  logic          busy,
  input  logic          done_flag,
  input  logic [AW-1:0] cur_addr,
  input  logic [CW-1:0] remaining,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] start_q,
  output logic [CW-1:0] count_q,
  output logic          ctrl_wr,
  output ctrl_t         ctrl_in,
  output logic          ram_we,
  output logic          cpu_oe,
  output logic [DW-1:0] cpu_rdata
);
  logic sel, ptr_wr, dat_wr, dat_rd, is_reg;
  logic start_wr, count_wr;
  logic [DW-1:0] reg_rdata;

  assign sel    = ~cs_n & dma_ack_n;
  assign ptr_wr = sel & ~wr_n & ~a0;
  assign dat_wr = sel & ~wr_n & a0;
  assign dat_rd = sel & ~rd_n & a0;
  assign is_reg = (ptr_q < AW'(NUM_REGS));

  assign ctrl_wr  = dat_wr & (ptr_q == AW'(RIDX_CTRL));
  assign start_wr = dat_wr & (ptr_q == AW'(RIDX_START));
  assign count_wr = dat_wr & (ptr_q == AW'(RIDX_COUNT));
  assign ctrl_in  = ctrl_t'(din[1:0]);

  assign ram_we = dat_wr & ~is_reg & ~busy;
  assign cpu_oe = dat_rd & (is_reg | ~busy);

  always_comb begin
    reg_rdata = '0;
    case (ptr_q)
      AW'(RIDX_START): reg_rdata = DW'(cur_addr);
      AW'(RIDX_COUNT): reg_rdata = DW'(remaining);
      AW'(RIDX_STAT):  reg_rdata = DW'({busy, done_flag});
      default:         reg_rdata = '0;
    endcase
  end

  assign cpu_rdata = is_reg ? reg_rdata : ram_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      start_q <= '0;
      count_q <= '0;
    end else begin
      if (ptr_wr)   ptr_q   <= din[AW-1:0];
      if (start_wr) start_q <= din[AW-1:0];
      if (count_wr) count_q <= din[CW-1:0];
    end
  end
endmodule

// File: rtl/dmaeng_seq.sv
module dmaeng_seq
  import dmaeng_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          ctrl_wr,
  input  ctrl_t         ctrl_in,
  input  logic [AW-1:0] start_val,
  input  logic [CW-1:0] count_val,
  input  logic          dma_ack_n,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic          active,
  output logic          dir,
  output logic          beat,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] remaining,
  output logic          done_flag,
  output logic          done_pulse
);
  logic          active_d, dir_d, done_d, pulse_d;
  logic [AW-1:0] addr_d;
  logic [CW-1:0] cnt_d;

  assign beat = active & slave_mode & ~dma_ack_n & (dir ? ~rd_n : ~wr_n);

  always_comb begin
    active_d = active;
    dir_d    = dir;
    done_d   = done_flag;
    pulse_d  = 1'b0;
    addr_d   = cur_addr;
    cnt_d    = remaining;
    if (ctrl_wr) begin
      dir_d = ctrl_in.dir;
      if (ctrl_in.en) begin
        addr_d = start_val;
        cnt_d  = count_val;
        if (count_val == '0) begin
          active_d = 1'b0;
          done_d   = 1'b1;
          pulse_d  = 1'b1;
        end else begin
          active_d = 1'b1;
          done_d   = 1'b0;
        end
      end else begin
        active_d = 1'b0;
      end
    end else if (beat) begin
      addr_d = cur_addr + 1'b1;
      cnt_d  = remaining - 1'b1;
      if (remaining == CW'(1)) begin
        active_d = 1'b0;
        done_d   = 1'b1;
        pulse_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      dir        <= 1'b0;
      done_flag  <= 1'b0;
      done_pulse <= 1'b0;
      cur_addr   <= '0;
      remaining  <= '0;
    end else begin
      active     <= active_d;
      dir        <= dir_d;
      done_flag  <= done_d;
      done_pulse <= pulse_d;
      cur_addr   <= addr_d;
      remaining  <= cnt_d;
    end
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dmaeng_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned AW          = 8,
  parameter int unsigned CW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          a0,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic          dma_ack_n,
  output logic          dma_req_n,
  output logic          xfer_done,
  output logic          done_pulse
);
  logic          rst_sync_n;
  logic          seq_active, seq_dir, seq_beat, seq_done;
  logic [AW-1:0] seq_addr, ptr_q, start_q, ram_addr;
  logic [CW-1:0] seq_remaining, count_q;
  logic          ctrl_wr, cpu_ram_we, cpu_oe, ram_we, dma_rd_beat;
  ctrl_t         ctrl_in;
  logic [DW-1:0] ram_rdata, cpu_rdata, ram_wdata;

  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      logic rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= 1'b0;
        else        rs_q <= 1'b1;
      end
      assign rst_sync_n = rs_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = rs_q[SYNC_STAGES-1];
    end
  endgenerate

  dmaeng_hostif #(.DW(DW), .AW(AW), .CW(CW)) u_hostif (
    .clk(clk), .rst_n(rst_sync_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .a0(a0), .dma_ack_n(dma_ack_n), .din(bus_din), .busy(seq_active),
    .done_flag(seq_done), .cur_addr(seq_addr), .remaining(seq_remaining),
    .ram_rdata(ram_rdata), .ptr_q(ptr_q), .start_q(start_q),
    .count_q(count_q), .ctrl_wr(ctrl_wr), .ctrl_in(ctrl_in),
    .ram_we(cpu_ram_we), .cpu_oe(cpu_oe), .cpu_rdata(cpu_rdata)
  );

  dmaeng_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .slave_mode(slave_mode),
    .ctrl_wr(ctrl_wr), .ctrl_in(ctrl_in), .start_val(start_q),
    .count_val(count_q), .dma_ack_n(dma_ack_n), .rd_n(rd_n), .wr_n(wr_n),
    .active(seq_active), .dir(seq_dir), .beat(seq_beat),
    .cur_addr(seq_addr), .remaining(seq_remaining),
    .done_flag(seq_done), .done_pulse(done_pulse)
  );

  // Processor buffer access is refused while active, so the port is free.
  assign ram_addr    = seq_active ? seq_addr : ptr_q;
  assign ram_we      = cpu_ram_we | (seq_beat & ~seq_dir);
  assign ram_wdata   = bus_din;
  assign dma_rd_beat = seq_beat & seq_dir;

  dmaeng_buf #(.DW(DW), .AW(AW)) u_buf (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  assign bus_dout  = dma_rd_beat ? ram_rdata : cpu_rdata;
  assign bus_oe    = dma_rd_beat | cpu_oe;
  assign dma_req_n = ~(seq_active & slave_mode);
  assign xfer_done = seq_done;
endmodule

// File: rtl/dmaeng_chk.sv
module dmaeng_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slave_mode,
  input logic          rd_n,
  input logic          bus_oe,
  input logic          dma_req_n,
  input logic          xfer_done,
  input logic          done_pulse,
  input logic          beat,
  input logic [CW-1:0] remaining
);
  p_host_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_mode |-> dma_req_n);

  p_req_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req_n |-> !xfer_done);

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (remaining == CW'($past(remaining) - 1'b1)));

  p_oe_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !rd_n);

  p_pulse_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (dma_req_n && xfer_done));

  p_pulse_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (remaining == '0));
endmodule

bind dma_xfer_engine dmaeng_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .slave_mode(slave_mode), .rd_n(rd_n),
  .bus_oe(bus_oe), .dma_req_n(dma_req_n), .xfer_done(xfer_done),
  .done_pulse(done_pulse), .beat(seq_beat), .remaining(seq_remaining)
);

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;
  logic clk = 1'b0;
  logic rst_n, slave_mode, cs_n, rd_n, wr_n, a0, dma_ack_n;
  logic [7:0] bus_din, bus_dout;
  logic bus_oe, dma_req_n, xfer_done, done_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] shadow [256];

  always #4 clk = ~clk;

  dma_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .a0(a0), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .dma_ack_n(dma_ack_n),
    .dma_req_n(dma_req_n), .xfer_done(xfer_done), .done_pulse(done_pulse)
  );

  function automatic logic [7:0] exp_stat(input bit busy, input bit done);
    return {6'd0, busy, done};
  endfunction

  function automatic logic [7:0] exp_end_addr(input logic [7:0] s, input int n);
    return s + n[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; a0 = sel; bus_din = d;
    @(posedge clk);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic cpu_rd(output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; a0 = 1'b1;
    #1;
    d = bus_dout; oe = bus_oe;
    @(posedge clk);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic reg_wr(input logic [7:0] p, input logic [7:0] d);
    cpu_wr(1'b0, p);
    cpu_wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] p, output logic [7:0] d);
    logic oe;
    cpu_wr(1'b0, p);
    cpu_rd(d, oe);
  endtask

  task automatic dma_wbeat(input logic [7:0] d);
    @(negedge clk);
    dma_ack_n = 1'b0; wr_n = 1'b0; bus_din = d;
    @(posedge clk);
    @(negedge clk);
    dma_ack_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic dma_rbeat(output logic [7:0] d, output logic oe);
    @(negedge clk);
    dma_ack_n = 1'b0; rd_n = 1'b0;
    #1;
    d = bus_dout; oe = bus_oe;
    @(posedge clk);
    @(negedge clk);
    dma_ack_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd, s, d;
    logic oe;
    int n;
    bit dr;
    void'($urandom(32'd1234));
    rst_n = 1'b0; slave_mode = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    a0 = 1'b0; dma_ack_n = 1'b1; bus_din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(dma_req_n === 1'b1, "R10 req", dma_req_n, 1);
    chk(xfer_done === 1'b0 && done_pulse === 1'b0, "R10 done", xfer_done, 0);
    chk(bus_oe === 1'b0, "R10 oe", bus_oe, 0);
    reg_rd(8'd3, rd); chk(rd === exp_stat(0, 0), "R10 status", rd, 0);
    reg_rd(8'd2, rd); chk(rd === 8'd0, "R10 count", rd, 0);
    reg_rd(8'd1, rd); chk(rd === 8'd0, "R10 addr", rd, 0);

    // R1 buffer access through pointer
    reg_wr(8'd250, 8'hA5); shadow[250] = 8'hA5;
    reg_wr(8'd40, 8'h3C);  shadow[40] = 8'h3C;
    reg_rd(8'd250, rd); chk(rd === 8'hA5, "R1 buffer readback", rd, 8'hA5);
    reg_rd(8'd40, rd);  chk(rd === 8'h3C, "R1 buffer readback", rd, 8'h3C);

    // R7 zero count
    reg_wr(8'd1, 8'd40); reg_wr(8'd2, 8'd0);
    reg_wr(8'd0, 8'h01);
    chk(dma_req_n === 1'b1, "R7 no request", dma_req_n, 1);
    chk(xfer_done === 1'b1 && done_pulse === 1'b1, "R7 done", {xfer_done, done_pulse}, 3);
    @(negedge clk);
    chk(done_pulse === 1'b0, "R7 pulse width", done_pulse, 0);

    // R2 host mode: no request, acks ignored
    slave_mode = 1'b0;
    reg_wr(8'd1, 8'd40); reg_wr(8'd2, 8'd5); reg_wr(8'd0, 8'h01);
    chk(dma_req_n === 1'b1, "R2 host request", dma_req_n, 1);
    dma_wbeat(8'hEE);
    chk(dma_req_n === 1'b1, "R2 host request", dma_req_n, 1);
    reg_rd(8'd2, rd); chk(rd === 8'd5, "R2 count held", rd, 5);
    slave_mode = 1'b1;
    @(negedge clk);
    chk(dma_req_n === 1'b0, "R3 request in slave", dma_req_n, 0);

    // R9 abort mid-transfer
    dma_wbeat(8'h11); dma_wbeat(8'h22); shadow[40] = 8'h11; shadow[41] = 8'h22;
    reg_wr(8'd0, 8'h00);
    chk(dma_req_n === 1'b1, "R9 request dropped", dma_req_n, 1);
    chk(xfer_done === 1'b0, "R9 done low", xfer_done, 0);
    reg_rd(8'd2, rd); chk(rd === 8'd3, "R9 count held", rd, 3);
    reg_rd(8'd41, rd); chk(rd === 8'h22, "R4 byte stored", rd, 8'h22);
    reg_rd(8'd40, rd); chk(rd === 8'h11, "R4 byte stored", rd, 8'h11);

    // Random transfers
    for (int t = 0; t < 24; t++) begin
      dr = 1'($urandom % 2);
      n  = 1 + int'($urandom % 16);
      s  = 8'(4 + ($urandom % 200));
      if (dr) begin
        for (int i = 0; i < n; i++) begin
          d = 8'($urandom);
          reg_wr(s + 8'(i), d); shadow[s + 8'(i)] = d;
        end
      end
      reg_wr(8'd1, s); reg_wr(8'd2, 8'(n));
      reg_wr(8'd0, {6'd0, dr, 1'b1});
      chk(dma_req_n === 1'b0, "R3 request", dma_req_n, 0);
      cpu_wr(1'b0, 8'd250);
      for (int i = 0; i < n; i++) begin
        repeat ($urandom % 3) @(negedge clk);
        if (i == 1) begin
          cpu_wr(1'b1, 8'h5A);
          cpu_rd(rd, oe);
          chk(oe === 1'b0, "R8 blocked read", oe, 0);
        end
        if (dr) begin
          dma_rbeat(rd, oe);
          chk(oe === 1'b1 && rd === shadow[s + 8'(i)], "R5 read beat", rd, shadow[s + 8'(i)]);
        end else begin
          d = 8'($urandom);
          dma_wbeat(d); shadow[s + 8'(i)] = d;
        end
      end
      chk(dma_req_n === 1'b1 && xfer_done === 1'b1 && done_pulse === 1'b1,
          "R6 completion", {dma_req_n, xfer_done, done_pulse}, 7);
      @(negedge clk);
      chk(done_pulse === 1'b0, "R6 pulse width", done_pulse, 0);
      reg_rd(8'd1, rd); chk(rd === exp_end_addr(s, n), "R4 end address", rd, exp_end_addr(s, n));
      reg_rd(8'd2, rd); chk(rd === 8'd0, "R4 count zero", rd, 0);
      reg_rd(8'd3, rd); chk(rd === exp_stat(0, 1), "R1 status", rd, exp_stat(0, 1));
      if (!dr) begin
        for (int i = 0; i < n; i++) begin
          reg_rd(s + 8'(i), rd);
          chk(rd === shadow[s + 8'(i)], "R4 stored byte", rd, shadow[s + 8'(i)]);
        end
      end
      reg_rd(8'd250, rd); chk(rd === 8'hA5, "R8 guard byte", rd, 8'hA5);
    end

    finish_run();
  end
endmodule